// File: doc/BRIEF.md
# Sector Multi-Error Correction Apply Engine

This block sits behind a 4-bit-capable BCH-style decoder in a flash controller and applies what that decoder found to a 512-byte sector held in a byte-wide RAM. The decoder is outside the block. The block takes a snapshot of the decoder's results when `start` is pulsed. These results are the ten stored parity bytes, four syndrome words, a completion state code, a 2-bit error-count field, and up to four location/value pairs. From the snapshot the block decides whether the sector is clean, uncorrectable or correctable.

For a correctable sector the block turns each reported location into a byte index by subtracting it from 519. It skips indices that fall outside the 512 data bytes. For every remaining error it reads the byte, XORs in the error value and writes the result back, one error after another. When the work is finished it pulses `done` and presents a signed status. The status is the reported error count, zero for a clean or erased sector, or -1 for failure.

Top module: `sector_ecc_apply`

## Requirements
- R1: If every one of the ten parity bytes (byte j at `parity_bytes[8j+7:8j]`) equals 0xFF, the sector is treated as erased. The result is status 0 with no RAM access, whatever the syndromes and state code are.
- R2: Otherwise, if all four syndrome words are zero, the result is status 0 with no RAM access.
- R3: Otherwise, state code 0 gives status 0, and state code 1 or any code from 4 to 15 gives status -1 (4'b1111). In all three cases there is no RAM access.
- R4: State codes 2 and 3 give an error count equal to `err_field` + 1 (1 to 4). The status is this count even when some of the errors are skipped.
- R5: Error k takes its location from `loc_words[10k+9:10k]` and its value from `val_words[8k+7:8k]`. Its byte index is 519 minus the location.
- R6: An error whose index is not below 512 (location below 8 or above 519) is skipped with no RAM access.
- R7: Each applied error produces one RAM read of its index and then one write of (read data XOR value) to the same index. Errors are handled in order k = 0 upward, so two errors on the same byte combine.
- R8: `done` is a one-cycle pulse that comes after the last RAM write, with no RAM request active in that cycle. `status` holds its value until the next `done`. RAM read data is expected one cycle after `mem_rd_en`.
- R9: A `start` pulse that arrives while a sector is being processed is ignored.
- R10: After reset, `done` is 0, `status` is 0, and there are no RAM requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Capture decoder results and begin |
| parity_bytes | input | 80 | Stored parity bytes of the sector |
| syndromes | input | 40 | Four 10-bit syndrome words |
| corr_state | input | 4 | Decoder completion state code |
| err_field | input | 2 | Error count minus one |
| loc_words | input | 40 | Four 10-bit error locations |
| val_words | input | 32 | Four 8-bit error values |
| done | output | 1 | Result pulse |
| status | output | 4 | Signed result: count, 0, or -1 |
| mem_rd_en | output | 1 | Sector RAM read request |
| mem_we | output | 1 | Sector RAM write enable |
| mem_addr | output | 9 | Sector RAM byte address |
| mem_wdata | output | 8 | Sector RAM write data |
| mem_rdata | input | 8 | Sector RAM read data, one-cycle latency |

## Verification
The hardest situation to reach is a read-modify-write that depends on an earlier write to the same byte in the same sector. It only occurs if two reported errors name one location and the second read follows the first write at once. The stimulus reports the same location twice with complementary values and expects the byte to be flipped by their XOR. A second hard case is a `start` pulse during an active correction. The bench raises it on the cycle after a real start, using inputs that would otherwise produce a failure status.

// File: rtl/sector_ecc_apply_pkg.sv
package sector_ecc_apply_pkg;
  typedef enum logic [2:0] {
    S_IDLE,
    S_DECIDE,
    S_NEXT,
    S_RD,
    S_WR
  } apply_state_t;

  localparam logic [3:0] CODE_CLEAN    = 4'd0;
  localparam logic [3:0] CODE_TOO_MANY = 4'd1;
  localparam logic [3:0] CODE_LAST_OK  = 4'd3;
endpackage

// File: rtl/erase_detect.sv
module erase_detect #(
  parameter int PARITY_BYTES = 10
) (
  input  logic [8*PARITY_BYTES-1:0] parity,
  output logic                      erased
);
  logic [PARITY_BYTES-1:0] byte_ff;

  for (genvar j = 0; j < PARITY_BYTES; j++) begin : g_byte
    assign byte_ff[j] = (parity[8*j +: 8] == 8'hFF);
  end

  assign erased = &byte_ff;
endmodule

// File: rtl/err_unpack.sv
module err_unpack #(
  parameter int MAX_ERR      = 4,
  parameter int LOC_W        = 10,
  parameter int VAL_W        = 8,
  parameter int SECTOR_BYTES = 512,
  parameter int LOC_BIAS     = 519,
  parameter int ADDR_W       = $clog2(SECTOR_BYTES)
) (
  input  logic [MAX_ERR*LOC_W-1:0]             loc_words,
  input  logic [MAX_ERR*VAL_W-1:0]             val_words,
  output logic [MAX_ERR-1:0][ADDR_W-1:0]       idx,
  output logic [MAX_ERR-1:0][VAL_W-1:0]        val,
  output logic [MAX_ERR-1:0]                   in_range
);
  localparam int             LOW_LOC = LOC_BIAS - SECTOR_BYTES + 1;
  localparam logic [LOC_W:0] BIAS_V  = (LOC_W + 1)'(LOC_BIAS);

  for (genvar k = 0; k < MAX_ERR; k++) begin : g_err
    logic [LOC_W-1:0] loc;
    logic [LOC_W:0]   diff;
    assign loc         = loc_words[k*LOC_W +: LOC_W];
    assign diff        = BIAS_V - {1'b0, loc};
    assign idx[k]      = diff[ADDR_W-1:0];
    assign val[k]      = val_words[k*VAL_W +: VAL_W];
    assign in_range[k] = (int'(loc) >= LOW_LOC) && (int'(loc) <= LOC_BIAS);
  end
endmodule

// File: rtl/sector_ecc_apply.sv
module sector_ecc_apply
  import sector_ecc_apply_pkg::*;
#(
  parameter int SECTOR_BYTES = 512,
  parameter int PARITY_BYTES = 10,
  parameter int MAX_ERR      = 4,
  parameter int SYN_W        = 10,
  parameter int LOC_W        = 10,
  parameter int VAL_W        = 8,
  parameter int LOC_BIAS     = 519,
  parameter int STAT_W       = 4,
  parameter int ADDR_W       = $clog2(SECTOR_BYTES),
  parameter int CNT_W        = $clog2(MAX_ERR)
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          start,
  input  logic [8*PARITY_BYTES-1:0]     parity_bytes,
  input  logic [MAX_ERR*SYN_W-1:0]      syndromes,
  input  logic [3:0]                    corr_state,
  input  logic [CNT_W-1:0]              err_field,
  input  logic [MAX_ERR*LOC_W-1:0]      loc_words,
  input  logic [MAX_ERR*VAL_W-1:0]      val_words,
  output logic                          done,
  output logic signed [STAT_W-1:0]      status,
  output logic                          mem_rd_en,
  output logic                          mem_we,
  output logic [ADDR_W-1:0]             mem_addr,
  output logic [VAL_W-1:0]              mem_wdata,
  input  logic [VAL_W-1:0]              mem_rdata
);
  apply_state_t st;

  logic [8*PARITY_BYTES-1:0] cap_parity;
  logic [MAX_ERR*SYN_W-1:0]  cap_syn;
  logic [3:0]                cap_code;
  logic [CNT_W-1:0]          cap_field;
  logic [MAX_ERR*LOC_W-1:0]  cap_loc;
  logic [MAX_ERR*VAL_W-1:0]  cap_val;
  logic [CNT_W:0]            k_cnt;

  logic                              erased;
  logic [MAX_ERR-1:0][ADDR_W-1:0]    e_idx;
  logic [MAX_ERR-1:0][VAL_W-1:0]     e_val;
  logic [MAX_ERR-1:0]                e_ok;
  logic [CNT_W:0]                    n_err;
  logic                              syn_nz, is_clean, is_fail;
  logic [CNT_W-1:0]                  k_sel;

  erase_detect #(.PARITY_BYTES(PARITY_BYTES)) u_erase (
    .parity (cap_parity),
    .erased (erased)
  );

  err_unpack #(
    .MAX_ERR(MAX_ERR), .LOC_W(LOC_W), .VAL_W(VAL_W),
    .SECTOR_BYTES(SECTOR_BYTES), .LOC_BIAS(LOC_BIAS), .ADDR_W(ADDR_W)
  ) u_unpack (
    .loc_words (cap_loc),
    .val_words (cap_val),
    .idx       (e_idx),
    .val       (e_val),
    .in_range  (e_ok)
  );

  assign n_err    = {1'b0, cap_field} + (CNT_W + 1)'(1);
  assign syn_nz   = |cap_syn;
  assign is_clean = erased || !syn_nz || (cap_code == CODE_CLEAN);
  assign is_fail  = (cap_code == CODE_TOO_MANY) || (cap_code > CODE_LAST_OK);
  assign k_sel    = k_cnt[CNT_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= S_IDLE;
      done       <= 1'b0;
      status     <= '0;
      mem_rd_en  <= 1'b0;
      mem_we     <= 1'b0;
      mem_addr   <= '0;
      mem_wdata  <= '0;
      k_cnt      <= '0;
      cap_parity <= '0;
      cap_syn    <= '0;
      cap_code   <= '0;
      cap_field  <= '0;
      cap_loc    <= '0;
      cap_val    <= '0;
    end else begin
      done      <= 1'b0;
      mem_rd_en <= 1'b0;
      mem_we    <= 1'b0;
      case (st)
        S_IDLE: begin
          if (start) begin
            cap_parity <= parity_bytes;
            cap_syn    <= syndromes;
            cap_code   <= corr_state;
            cap_field  <= err_field;
            cap_loc    <= loc_words;
            cap_val    <= val_words;
            k_cnt      <= '0;
            st         <= S_DECIDE;
          end
        end
        S_DECIDE: begin
          if (is_clean) begin
            done   <= 1'b1;
            status <= '0;
            st     <= S_IDLE;
          end else if (is_fail) begin
            done   <= 1'b1;
            status <= '1;
            st     <= S_IDLE;
          end else begin
            st <= S_NEXT;
          end
        end
        S_NEXT: begin
          if (k_cnt == n_err) begin
            done   <= 1'b1;
            status <= STAT_W'(n_err);
            st     <= S_IDLE;
          end else if (e_ok[k_sel]) begin
            mem_rd_en <= 1'b1;
            mem_addr  <= e_idx[k_sel];
            st        <= S_RD;
          end else begin
            k_cnt <= k_cnt + 1'b1;
          end
        end
        S_RD: st <= S_WR;
        S_WR: begin
          mem_we    <= 1'b1;
          mem_wdata <= mem_rdata ^ e_val[k_sel];
          k_cnt     <= k_cnt + 1'b1;
          st        <= S_NEXT;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_quiet_done_R8: assert property (@(posedge clk) disable iff (rst)
    done |-> (!mem_we && !mem_rd_en));

  assert_write_follows_read_R7: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> ($past(mem_rd_en, 2) && mem_addr == $past(mem_addr, 2)));

  assert_erased_zero_R1: assert property (@(posedge clk) disable iff (rst)
    (st == S_DECIDE && erased) |=> (done && status == '0));

  assert_fail_code_R3: assert property (@(posedge clk) disable iff (rst)
    (st == S_DECIDE && !erased && syn_nz && cap_code == CODE_TOO_MANY)
      |=> (done && status == '1));

  assert_status_range_R4: assert property (@(posedge clk) disable iff (rst)
    done |-> (status >= -1 && int'(status) <= MAX_ERR));
endmodule

// File: tb/sector_ecc_apply_tb_top.sv
module sector_ecc_apply_tb_top;
  logic               clk = 1'b0;
  logic               rst = 1'b1;
  logic               start = 1'b0;
  logic [79:0]        parity_bytes = '0;
  logic [39:0]        syndromes = '0;
  logic [3:0]         corr_state = '0;
  logic [1:0]         err_field = '0;
  logic [39:0]        loc_words = '0;
  logic [31:0]        val_words = '0;
  logic               done;
  logic signed [3:0]  status;
  logic               mem_rd_en, mem_we;
  logic [8:0]         mem_addr;
  logic [7:0]         mem_wdata;
  logic [7:0]         mem_rdata = '0;

  logic [7:0] ram [512];
  logic [7:0] shadow [512];

  int checks = 0;
  int errors = 0;
  int exp_status_q[$];
  int exp_wr_q[$];
  string tag_q[$];
  int wr_seen = 0;
  int cycles = 0;

  always #2 clk = ~clk;

  sector_ecc_apply dut_i (
    .clk(clk), .rst(rst), .start(start), .parity_bytes(parity_bytes),
    .syndromes(syndromes), .corr_state(corr_state), .err_field(err_field),
    .loc_words(loc_words), .val_words(val_words), .done(done), .status(status),
    .mem_rd_en(mem_rd_en), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  always @(posedge clk) begin
    if (mem_we) ram[mem_addr] <= mem_wdata;
    if (mem_rd_en) mem_rdata <= ram[mem_addr];
  end

  task automatic check(input bit ok, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  // Monitor: pops expected items when a result appears.
  always @(negedge clk) begin
    cycles++;
    if (mem_we) wr_seen++;
    if (done) begin
      if (exp_status_q.size() == 0) begin
        check(1'b0, "R9 unexpected done", 1, 0);
      end else begin
        int es, ew, bad;
        string t;
        es = exp_status_q.pop_front();
        ew = exp_wr_q.pop_front();
        t  = tag_q.pop_front();
        check(int'(status) == es, {t, " status"}, int'(status), es);
        check(wr_seen == ew, {t, " R7 write count"}, wr_seen, ew);
        bad = 0;
        for (int i = 0; i < 512; i++) if (ram[i] !== shadow[i]) bad++;
        check(bad == 0, {t, " R5 sector image mismatching bytes"}, bad, 0);
      end
      wr_seen = 0;
    end
  end

  // Driver: computes expected results from the requirements.
  task automatic run(input logic [79:0] par, input logic [39:0] syn,
                     input logic [3:0] code, input logic [1:0] fld,
                     input logic [39:0] locs, input logic [31:0] vals,
                     input bit poke, input string tag);
    int exp, wr;
    exp = 0; wr = 0;
    if (&par || syn == '0 || code == 4'd0) exp = 0;
    else if (code == 4'd1 || code > 4'd3) exp = -1;
    else begin
      exp = int'(fld) + 1;
      for (int k = 0; k < exp; k++) begin
        int loc;
        loc = int'(locs[10*k +: 10]);
        if (loc >= 8 && loc <= 519) begin
          shadow[519 - loc] = shadow[519 - loc] ^ vals[8*k +: 8];
          wr++;
        end
      end
    end
    exp_status_q.push_back(exp);
    exp_wr_q.push_back(wr);
    tag_q.push_back(tag);
    @(negedge clk);
    parity_bytes = par; syndromes = syn; corr_state = code;
    err_field = fld; loc_words = locs; val_words = vals; start = 1'b1;
    @(negedge clk);
    if (poke) begin
      corr_state = 4'd1; err_field = 2'd0; loc_words = '0;
      start = 1'b1;
      @(negedge clk);
    end
    start = 1'b0;
    while (exp_status_q.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    for (int i = 0; i < 512; i++) begin
      ram[i]    = 8'((i * 7 + 3) & 8'hFF);
      shadow[i] = 8'((i * 7 + 3) & 8'hFF);
    end
    repeat (3) @(negedge clk);
    // R10 reset state
    check(done == 1'b0, "R10 done in reset", int'(done), 0);
    check(status == 4'sd0, "R10 status in reset", int'(status), 0);
    check(mem_we == 1'b0 && mem_rd_en == 1'b0, "R10 RAM idle in reset",
          int'(mem_we) + int'(mem_rd_en), 0);
    rst = 1'b0;
    @(negedge clk);
    check(done == 1'b0 && mem_we == 1'b0, "R10 idle after reset", int'(done), 0);

    run({80{1'b1}}, 40'h1, 4'd3, 2'd0, {30'd0, 10'd20}, 32'h55, 0, "R1 erased");
    run({8'hFE, {72{1'b1}}}, 40'h3, 4'd3, 2'd0, {30'd0, 10'd260}, 32'h42, 0,
        "R1 one parity byte not FF");
    run(80'h0, 40'h0, 4'd3, 2'd1, {20'd0, 10'd30, 10'd40}, 32'h0909, 0,
        "R2 zero syndromes");
    run(80'h0, 40'h8, 4'd0, 2'd1, {20'd0, 10'd30, 10'd40}, 32'h0909, 0,
        "R3 state 0");
    run(80'h0, 40'h8, 4'd1, 2'd1, {20'd0, 10'd30, 10'd40}, 32'h0909, 0,
        "R3 state 1");
    run(80'h0, 40'h8, 4'd9, 2'd0, {30'd0, 10'd30}, 32'h09, 0, "R3 state 9");
    run(80'h0, 40'h123, 4'd3, 2'd3, {10'd8, 10'd300, 10'd200, 10'd100},
        32'h80_01_3C_A5, 0, "R4 R5 R7 four errors");
    run(80'h0, 40'h5, 4'd2, 2'd0, {30'd0, 10'd519}, 32'hFF, 0,
        "R5 R6 state 2 index 0");
    run(80'h0, 40'h5, 4'd3, 2'd2, {10'd0, 10'd50, 10'd600, 10'd3},
        32'h00_11_77_66, 0, "R6 out-of-range skipped R4 count");
    run(80'h0, 40'h7, 4'd3, 2'd1, {20'd0, 10'd77, 10'd77}, 32'h00_00_F0_0F, 0,
        "R7 same byte twice");
    run(80'h0, 40'h9, 4'd3, 2'd1, {20'd0, 10'd444, 10'd333}, 32'h00_00_12_34, 1,
        "R9 start while busy");
    check(exp_status_q.size() == 0, "R8 queue drained", exp_status_q.size(), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    wait (cycles > 100000);
    errors++;
    checks++;
    $display("FAIL watchdog R8 actual=%0d expected=%0d", cycles, 100000);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule